// File: doc/BRIEF.md
# Cartridge Halfword Prefetch Buffer

This block sits between a CPU instruction-fetch port and a slow 16-bit cartridge bus. It reads halfwords ahead of the CPU at sequential addresses and keeps them in an eight-entry circular store. The CPU can then often take its next halfword in the cycle it asks for it, without waiting for the cartridge. Each cartridge access costs a programmable number of cycles. The cost of the first access after a jump (nonsequential) is set separately from the cost of each later access in the stream (sequential). Both costs are chosen per address region.

The CPU holds `cpu_req` and `cpu_addr` until `cpu_stall` is low, and takes `cpu_rdata` in that same cycle. A requested address that is not the next expected one flushes the stream and restarts it at that address. When the CPU needs the cartridge bus for something else, it raises `cpu_other`. The block holds it off until the halfword being fetched has landed, and the access after it is then charged the nonsequential cost. Fetching stops while prefetch is disabled or a DMA transfer owns the bus. Wait-cost generation and DMA/CPU arbitration are outside the block.

Top module: `cart_prefetch_buf`

## Requirements
- R1: The asynchronous reset, whose release is synchronised by two flops, clears both pointers and the wait counter, leaving the store empty. With no request pending, `cpu_stall` and `cart_rd` are low. The first enabled cycle after reset fetches address 0.
- R2: The store has eight 16-bit slots. A slot is selected by address bits [3:1], on write and on read alike, so a run of reads wraps from slot 7 to slot 0 and returns each halfword of its address.
- R3: A request whose halfword-aligned address differs from the expected read address resynchronises the block and stalls for that cycle. Both pointers take the address and the wait counter takes the nonsequential cost of its region. That read completes after exactly 1 + N stalled cycles, where N is that cost.
- R4: In each cycle that fetching may run, a counter value of 1 or 0 fetches. The fetch is one `cart_rd` pulse at `cart_addr` = fetch pointer; `cart_rdata` goes into the slot and the fetch pointer moves up by 2. Any other counter value decrements by one.
- R5: After a fetch, the counter reloads with the sequential cost of the new fetch address, so in steady state a fetch occurs every S cycles. With S = 2, a back-to-back sequential reader stalls one cycle per read; with S = 1 it does not stall.
- R6: No fetch happens, and the counter holds, while `pf_en` is low or `dma_busy` is high. Fetching resumes from the held count afterwards.
- R7: A read from an empty store stalls. A read from a non-empty store completes in the same cycle with no stall and returns the slot at the read pointer, which then moves up by 2. A fetch may complete in that same cycle.
- R8: The fill level is (fetch pointer − read pointer)/2. At 8 halfwords the store is full and no fetch occurs. A read taken while full reloads the counter with the sequential cost of the fetch address at that moment.
- R9: `cpu_other` is stalled while `pf_en` is high, `dma_busy` is low and the store is not full. It is granted in the cycle the in-flight fetch completes, and the counter then takes the nonsequential cost of the new fetch address. Otherwise it is granted at once and changes nothing.
- R10: The region index is the top log2(REGIONS) address bits. Region k's nonsequential and sequential costs sit in bits [4k+3:4k] of `ncost` and `scost`. Each cost is a 4-bit cycle count of at least 1.
- R11: When `cpu_req` and `cpu_other` are both high, the read is served and `cpu_other` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_en | input | 1 | Prefetch enable |
| dma_busy | input | 1 | DMA owns the cartridge bus |
| cpu_req | input | 1 | CPU halfword read request, held until not stalled |
| cpu_other | input | 1 | CPU needs the cartridge bus for another access |
| cpu_addr | input | ADDR_W | CPU read byte address (halfword aligned) |
| cpu_rdata | output | 16 | Returned halfword, valid when request and not stalled |
| cpu_stall | output | 1 | Holds the current CPU request or other access |
| cart_addr | output | ADDR_W | Cartridge read byte address |
| cart_rd | output | 1 | One-cycle cartridge read strobe |
| cart_rdata | input | 16 | Cartridge data for `cart_addr`, same cycle |
| ncost | input | 4*REGIONS | Per-region nonsequential cost |
| scost | input | 4*REGIONS | Per-region sequential cost |

## Verification
The in-line assertions check the following on every cycle:
- the cartridge strobe is silent while frozen or full;
- a completed read never comes from an empty store;
- a resync lands both pointers on the requested address;
- each fetch and each read advances its pointer by exactly one halfword;
- the counter reload after a fetch takes the sequential or the nonsequential cost, as the other-access state requires.

Only the directed scenarios can show the rest:
- the end-to-end stall counts (1 + N on a jump, the steady-state rate for S = 1 and S = 2);
- the exact number of fetches needed to fill the store;
- wrap-around data across slot 7 to 0;
- the reload taken on a read while full;
- the delay to the next fetch after a granted other access.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int unsigned COST_W = 4;
  localparam int unsigned HALF_W = 16;

  typedef logic [COST_W-1:0] cost_t;
  typedef logic [HALF_W-1:0] half_t;

  // Source of the next wait-counter value
  typedef enum logic [2:0] {
    WL_HOLD,
    WL_DEC,
    WL_NS_REQ,
    WL_NS_NEXT,
    WL_SQ_NEXT,
    WL_SQ_CUR
  } wait_load_e;
endpackage

// File: rtl/pfb_cost_lut.sv
module pfb_cost_lut
  import pfb_pkg::*;
#(
  parameter int unsigned REGIONS = 4,
  localparam int unsigned RB = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic [RB-1:0]             region,
  input  logic [REGIONS*COST_W-1:0] costs,
  output cost_t                     cost
);
  cost_t tbl [REGIONS];

  genvar g;
  generate
    for (g = 0; g < REGIONS; g++) begin : g_tbl
      assign tbl[g] = costs[g*COST_W +: COST_W];
    end
  endgenerate

  // Indices beyond the populated regions fall back to the last entry
  always_comb begin
    if (32'(region) < REGIONS) cost = tbl[region];
    else                       cost = tbl[REGIONS-1];
  end
endmodule

// File: rtl/pfb_slot_store.sv
module pfb_slot_store
  import pfb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  half_t            wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output half_t            rd_data
);
  half_t            slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_we
      assign slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
    end
  endgenerate

  // Data slots carry no reset: a slot is read only after it was written
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slot_q[i] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
  import pfb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned REGIONS = 4,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned RB     = (REGIONS > 1) ? $clog2(REGIONS) : 1,
  localparam int unsigned SPAN   = DEPTH * 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_en,
  input  logic              dma_busy,
  input  logic              cpu_req,
  input  logic              cpu_other,
  input  logic [ADDR_W-1:0] req_addr,
  input  cost_t             nc_req,
  input  cost_t             nc_nxt,
  input  cost_t             sc_nxt,
  input  cost_t             sc_cur,
  output logic [IDX_W-1:0]  rd_slot,
  output logic [ADDR_W-1:0] ft_ptr,
  output logic [RB-1:0]     nxt_region,
  output logic              fetch_now,
  output logic              cpu_stall
);
  logic [ADDR_W-1:0] rd_q, rd_d, ft_q, ft_d, ft_inc, span;
  logic              rd_en, ft_en, wait_en;
  cost_t             wait_q, wait_d;
  wait_load_e        wl_sel;
  logic              empty, full, resync, run, other_wait, rd_fire;

  // Occupancy from the pointer distance
  assign span   = ft_q - rd_q;
  assign empty  = (span == '0);
  assign full   = (span == ADDR_W'(SPAN));
  assign ft_inc = ft_q + ADDR_W'(2);

  // Request classification
  assign resync     = cpu_req && (req_addr != rd_q);
  assign run        = pf_en && !dma_busy && !full && !resync;
  assign fetch_now  = run && (wait_q <= COST_W'(1));
  assign other_wait = cpu_other && !cpu_req && pf_en && !dma_busy && !full;
  assign rd_fire    = cpu_req && !resync && !empty;
  assign cpu_stall  = (cpu_req && !rd_fire) || (other_wait && !fetch_now);

  // Wait-counter source
  always_comb begin
    if (resync)              wl_sel = WL_NS_REQ;
    else if (fetch_now)      wl_sel = other_wait ? WL_NS_NEXT : WL_SQ_NEXT;
    else if (run)            wl_sel = WL_DEC;
    else if (rd_fire && full) wl_sel = WL_SQ_CUR;
    else                     wl_sel = WL_HOLD;
  end

  always_comb begin
    wait_en = 1'b1;
    case (wl_sel)
      WL_NS_REQ:  wait_d = nc_req;
      WL_NS_NEXT: wait_d = nc_nxt;
      WL_SQ_NEXT: wait_d = sc_nxt;
      WL_SQ_CUR:  wait_d = sc_cur;
      WL_DEC:     wait_d = wait_q - COST_W'(1);
      default: begin
        wait_d  = wait_q;
        wait_en = 1'b0;
      end
    endcase
  end

  // Pointer next state
  always_comb begin
    rd_en = resync || rd_fire;
    rd_d  = resync ? req_addr : rd_q + ADDR_W'(2);
    ft_en = resync || fetch_now;
    ft_d  = resync ? req_addr : ft_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      ft_q   <= '0;
      wait_q <= '0;
    end else begin
      if (rd_en)   rd_q   <= rd_d;
      if (ft_en)   ft_q   <= ft_d;
      if (wait_en) wait_q <= wait_d;
    end
  end

  assign rd_slot    = rd_q[IDX_W:1];
  assign ft_ptr     = ft_q;
  assign nxt_region = ft_inc[ADDR_W-1 -: RB];

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    span <= ADDR_W'(SPAN)); // R8
  AST_RESYNC_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (rd_q == $past(req_addr)) && (ft_q == rd_q)); // R3
  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_now |=> ft_q == $past(ft_q) + ADDR_W'(2)); // R4
  AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_q == $past(rd_q) + ADDR_W'(2)); // R7
  AST_READ_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |-> (ft_q != rd_q)); // R7
  AST_SEQ_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_now && !cpu_other) |=> wait_q == $past(sc_nxt)); // R5
  AST_OTHER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_other && !cpu_req && !cpu_stall && fetch_now) |=> wait_q == $past(nc_nxt)); // R9
endmodule

// File: rtl/cart_prefetch_buf.sv
module cart_prefetch_buf
  import pfb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned REGIONS = 4,
  parameter int unsigned DEPTH   = 8,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned RB     = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pf_en,
  input  logic                      dma_busy,
  input  logic                      cpu_req,
  input  logic                      cpu_other,
  input  logic [ADDR_W-1:0]         cpu_addr,
  output logic [HALF_W-1:0]         cpu_rdata,
  output logic                      cpu_stall,
  output logic [ADDR_W-1:0]         cart_addr,
  output logic                      cart_rd,
  input  logic [HALF_W-1:0]         cart_rdata,
  input  logic [REGIONS*COST_W-1:0] ncost,
  input  logic [REGIONS*COST_W-1:0] scost
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [ADDR_W-1:0] req_addr, ft_ptr;
  logic [IDX_W-1:0]  rd_slot;
  logic [RB-1:0]     nxt_region;
  logic              fetch_now;
  cost_t             nc_req, nc_nxt, sc_nxt, sc_cur;

  // Reset asserts at once, releases on the second clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign req_addr = {cpu_addr[ADDR_W-1:1], 1'b0};

  pfb_cost_lut #(.REGIONS(REGIONS)) u_nc_req (
    .region(cpu_addr[ADDR_W-1 -: RB]), .costs(ncost), .cost(nc_req));
  pfb_cost_lut #(.REGIONS(REGIONS)) u_nc_nxt (
    .region(nxt_region), .costs(ncost), .cost(nc_nxt));
  pfb_cost_lut #(.REGIONS(REGIONS)) u_sc_nxt (
    .region(nxt_region), .costs(scost), .cost(sc_nxt));
  pfb_cost_lut #(.REGIONS(REGIONS)) u_sc_cur (
    .region(ft_ptr[ADDR_W-1 -: RB]), .costs(scost), .cost(sc_cur));

  pfb_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .REGIONS(REGIONS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pf_en      (pf_en),
    .dma_busy   (dma_busy),
    .cpu_req    (cpu_req),
    .cpu_other  (cpu_other),
    .req_addr   (req_addr),
    .nc_req     (nc_req),
    .nc_nxt     (nc_nxt),
    .sc_nxt     (sc_nxt),
    .sc_cur     (sc_cur),
    .rd_slot    (rd_slot),
    .ft_ptr     (ft_ptr),
    .nxt_region (nxt_region),
    .fetch_now  (fetch_now),
    .cpu_stall  (cpu_stall)
  );

  pfb_slot_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (fetch_now),
    .wr_idx  (ft_ptr[IDX_W:1]),
    .wr_data (cart_rdata),
    .rd_idx  (rd_slot),
    .rd_data (cpu_rdata)
  );

  assign cart_addr = ft_ptr;
  assign cart_rd   = fetch_now;

  AST_FROZEN_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pf_en || dma_busy) |-> !cart_rd); // R6
  AST_STROBE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_int_n)
    cart_rd |-> !cart_addr[0]); // R4
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_req |-> !cpu_addr[0]); // R3
endmodule

// File: tb/cart_prefetch_buf_test.sv
`timescale 1ns/1ps
module cart_prefetch_buf_test;
  localparam int ADDR_W = 16;
  localparam int REGIONS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pf_en, dma_busy, cpu_req, cpu_other;
  logic [15:0] cpu_addr, cpu_rdata, cart_addr, cart_rdata;
  logic        cpu_stall, cart_rd;
  logic [15:0] ncost, scost;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] half_of(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C96;
  endfunction

  assign cart_rdata = half_of(cart_addr);

  cart_prefetch_buf #(.ADDR_W(ADDR_W), .REGIONS(REGIONS)) uut (
    .clk(clk), .rst_n(rst_n), .pf_en(pf_en), .dma_busy(dma_busy),
    .cpu_req(cpu_req), .cpu_other(cpu_other), .cpu_addr(cpu_addr),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .cart_addr(cart_addr),
    .cart_rd(cart_rd), .cart_rdata(cart_rdata), .ncost(ncost), .scost(scost));

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic set_cost(input int r, input int n, input int s);
    ncost[r*4 +: 4] = 4'(n);
    scost[r*4 +: 4] = 4'(s);
  endtask

  // All tasks start and end at posedge+1
  task automatic do_read(input logic [15:0] a, input int exp_st,
                         input string rq, input bit with_other = 0);
    int st = 0;
    bit stalled;
    logic [15:0] got;
    cpu_req = 1'b1; cpu_addr = a; cpu_other = with_other;
    forever begin
      #2;
      stalled = cpu_stall;
      got = cpu_rdata;
      @(posedge clk); #1;
      if (!stalled || st > 100) break;
      st++;
    end
    cpu_other = 1'b0;
    chk(st == exp_st, rq, $sformatf("stalls for read %h", a), st, exp_st);
    chk(got == half_of(a), rq, $sformatf("data for read %h", a), got, half_of(a));
  endtask

  task automatic idle_count(input int n, output int fetches);
    fetches = 0;
    cpu_req = 1'b0; cpu_other = 1'b0;
    for (int i = 0; i < n; i++) begin
      #2;
      if (cart_rd) fetches++;
      @(posedge clk); #1;
    end
  endtask

  task automatic cycles_to_fetch(output int k);
    bit seen = 0;
    cpu_req = 1'b0; cpu_other = 1'b0; k = 0;
    while (!seen && k < 50) begin
      #2;
      seen = cart_rd;
      @(posedge clk); #1;
      if (!seen) k++;
    end
  endtask

  task automatic other_access(input int exp_st, input string rq);
    int st = 0;
    bit stalled;
    cpu_req = 1'b0; cpu_other = 1'b1;
    forever begin
      #2;
      stalled = cpu_stall;
      @(posedge clk); #1;
      if (!stalled || st > 100) break;
      st++;
    end
    cpu_other = 1'b0;
    chk(st == exp_st, rq, "other-access stalls", st, exp_st);
  endtask

  task automatic t_reset;
    pf_en = 0; dma_busy = 0; cpu_req = 0; cpu_other = 0; cpu_addr = 0;
    ncost = 16'h3333; scost = 16'h2222;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    #2;
    chk(cpu_stall == 0, "R1", "stall after reset", cpu_stall, 0);
    chk(cart_rd == 0, "R1", "strobe while disabled after reset", cart_rd, 0);
    @(posedge clk); #1;
    pf_en = 1;
    #2;
    chk(cart_rd == 1, "R1", "first enabled cycle fetches", cart_rd, 1);
    chk(cart_addr == 0, "R1", "first fetch address", cart_addr, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_resync_timing;
    set_cost(0, 3, 2);
    do_read(16'h0100, 4, "R3");
    do_read(16'h0102, 1, "R5");
    do_read(16'h0104, 1, "R5");
  endtask

  task automatic t_seq_fast;
    set_cost(0, 1, 1);
    do_read(16'h0300, 2, "R3");
    do_read(16'h0302, 0, "R7");
    do_read(16'h0304, 0, "R7");
  endtask

  task automatic t_fill_full;
    int f, k;
    set_cost(0, 2, 2);
    do_read(16'h0400, 3, "R3");
    idle_count(40, f);
    chk(f == 8, "R8", "fetches until full", f, 8);
    set_cost(0, 2, 5);
    do_read(16'h0402, 0, "R8");
    cycles_to_fetch(k);
    chk(k == 4, "R8", "cycles to fetch after read while full", k, 4);
    for (int i = 2; i <= 8; i++) do_read(16'(16'h0402 + 2*i - 2), 0, "R2");
    set_cost(0, 2, 2);
  endtask

  task automatic t_freeze;
    int f;
    set_cost(0, 2, 2);
    do_read(16'h0500, 3, "R3");
    pf_en = 0;
    idle_count(20, f);
    chk(f == 0, "R6", "fetches while disabled", f, 0);
    pf_en = 1; dma_busy = 1;
    idle_count(20, f);
    chk(f == 0, "R6", "fetches while DMA active", f, 0);
    dma_busy = 0;
    idle_count(20, f);
    chk(f == 8, "R6", "fetches after resume", f, 8);
  endtask

  task automatic t_regions;
    set_cost(1, 5, 2);
    set_cost(0, 3, 2);
    do_read(16'h4100, 6, "R10");
    do_read(16'h0100, 4, "R10");
  endtask

  task automatic t_other;
    int k, f;
    set_cost(0, 3, 4);
    do_read(16'h0600, 4, "R3");
    other_access(2, "R9");
    cycles_to_fetch(k);
    chk(k == 2, "R9", "cycles to fetch after granted other", k, 2);
    do_read(16'h0602, 0, "R9");
    do_read(16'h0604, 0, "R11", 1'b1);
    idle_count(60, f);
    other_access(0, "R9");
    pf_en = 0;
    do_read(16'h0606, 0, "R7");
    other_access(0, "R9");
    pf_en = 1;
  endtask

  initial begin
    t_reset();
    t_resync_timing();
    t_seq_fast();
    t_fill_full();
    t_freeze();
    t_regions();
    t_other();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule